// File: doc/BRIEF.md
# Oldest-First Wakeup and Select Scheduler

This block is the central instruction window of an out-of-order core. It holds up to `S` renamed instructions. Each instruction has a sequence tag, a two-bit operation type and two source operands. Every operand carries a "use" flag, a ready bit and the tag of the instruction that produces it. An operand whose use flag is clear stands for a missing register and is stored as ready.

Every cycle the window does three things. First, it compares the result tags that execution reports as completing against all waiting operands, and marks the matching operands ready. Second, it grants up to `N` ready entries to the execution units, youngest-last by sequence tag. Third, it writes up to `N` newly dispatched instructions into slots that are free after this cycle's grants.

Wakeup and selection are combinational within the cycle, so a consumer can leave the window in the same cycle its producer's completion is reported. The occupancy count is output so that the dispatch stage can stall.

Top module: `wakeup_select_sched`

## Requirements
- R1: While and after reset the window is empty: `occupancy` is 0 and no `iss_valid` bit is set.
- R2: An entry is a grant candidate only when every source whose use flag is 1 is ready. A source with use flag 0 counts as ready.
- R3: Up to `N` candidates are granted per cycle. Slot 0 gets the lowest tag, slot 1 the next lowest, and so on. Tags are compared as unsigned numbers over their full width. Grant slots fill from slot 0 with no gaps.
- R4: A granted entry leaves the window at the clock edge closing its grant cycle. `occupancy` always equals the number of held entries.
- R5: Completion tags on all `C` broadcast slots of a cycle wake matching operands in that same cycle, and a woken entry can be granted in that cycle.
- R6: A source woken by a broadcast stays ready in later cycles without further broadcasts.
- R7: Dispatched entries may take slots freed by grants in the same cycle. The dispatcher may present up to `S - occupancy +` (grants this cycle) valid entries, and all of them are stored.
- R8: An entry dispatched in a cycle cannot be granted before the next cycle.
- R9: A dispatched source whose producer tag is broadcast in the dispatch cycle is stored as ready.
- R10: A grant slot carries the granted entry's tag and operation type unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | N | Dispatch slot holds an instruction |
| disp_tag | input | N x TAG_W | Sequence tag per dispatch slot |
| disp_op | input | N x 2 | Operation type per dispatch slot |
| disp_s1_use | input | N | First source present |
| disp_s1_rdy | input | N | First source already available |
| disp_s1_tag | input | N x TAG_W | Producer tag of first source |
| disp_s2_use | input | N | Second source present |
| disp_s2_rdy | input | N | Second source already available |
| disp_s2_tag | input | N x TAG_W | Producer tag of second source |
| cmp_valid | input | C | Completion broadcast slot active |
| cmp_tag | input | C x TAG_W | Tag of the completing instruction |
| iss_valid | output | N | Grant slot active |
| iss_tag | output | N x TAG_W | Tag of granted instruction |
| iss_op | output | N x 2 | Operation type of granted instruction |
| occupancy | output | clog2(S+1) | Number of entries held |

## Verification
Two pairs of functions share a cycle here. Wakeup and grant share it when a broadcast releases a waiting entry. Grant and refill share it when dispatch writes into slots that are being granted away.

A sweep over every readiness pattern of a four-entry window covers the first pair. A final cycle broadcasts all producer tags at once, and the grants of that cycle are compared with the two lowest tags still held. A directed sequence covers the second pair. It fills the window, then in one cycle wakes it, grants two entries and dispatches two more, one of them caught by that same broadcast. Occupancy and later grants are then checked against counts computed in the bench.

// File: rtl/wakeup_select_sched.sv
module wakeup_select_sched #(
  parameter int S     = 8,
  parameter int N     = 2,
  parameter int C     = 4,
  parameter int TAG_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N-1:0]                disp_valid,
  input  logic [N-1:0][TAG_W-1:0]     disp_tag,
  input  logic [N-1:0][1:0]           disp_op,
  input  logic [N-1:0]                disp_s1_use,
  input  logic [N-1:0]                disp_s1_rdy,
  input  logic [N-1:0][TAG_W-1:0]     disp_s1_tag,
  input  logic [N-1:0]                disp_s2_use,
  input  logic [N-1:0]                disp_s2_rdy,
  input  logic [N-1:0][TAG_W-1:0]     disp_s2_tag,
  input  logic [C-1:0]                cmp_valid,
  input  logic [C-1:0][TAG_W-1:0]     cmp_tag,
  output logic [N-1:0]                iss_valid,
  output logic [N-1:0][TAG_W-1:0]     iss_tag,
  output logic [N-1:0][1:0]           iss_op,
  output logic [$clog2(S+1)-1:0]      occupancy
);
  localparam int IW = $clog2(S);
  localparam int CW = $clog2(S+1);

  logic [S-1:0]       e_v, e_r1, e_r2;
  logic [TAG_W-1:0]   e_tag [S];
  logic [TAG_W-1:0]   e_t1  [S];
  logic [TAG_W-1:0]   e_t2  [S];
  logic [1:0]         e_op  [S];

  logic [S-1:0]       w1, w2, cand, taken;
  logic [N-1:0]       put;
  logic [IW-1:0]      put_idx [N];
  logic [N-1:0]       d1r, d2r;
  logic [CW-1:0]      iss_cnt, disp_cnt, free_cnt;

  function automatic logic hit(input logic [TAG_W-1:0] t,
                               input logic [C-1:0] cv,
                               input logic [C-1:0][TAG_W-1:0] ct);
    logic h;
    h = 1'b0;
    for (int c = 0; c < C; c++)
      if (cv[c] && ct[c] == t) h = 1'b1;
    return h;
  endfunction

  always_comb begin
    logic             found;
    int               bi;
    logic [TAG_W-1:0] bt;
    logic [S-1:0]     busy;

    for (int i = 0; i < S; i++) begin
      w1[i]   = e_r1[i] | hit(e_t1[i], cmp_valid, cmp_tag);
      w2[i]   = e_r2[i] | hit(e_t2[i], cmp_valid, cmp_tag);
      cand[i] = e_v[i] & w1[i] & w2[i];
    end

    taken = '0;
    for (int k = 0; k < N; k++) begin
      found = 1'b0;
      bi    = 0;
      bt    = '0;
      for (int i = 0; i < S; i++)
        if (cand[i] && !taken[i] && (!found || e_tag[i] < bt)) begin
          found = 1'b1;
          bi    = i;
          bt    = e_tag[i];
        end
      iss_valid[k] = found;
      iss_tag[k]   = bt;
      iss_op[k]    = found ? e_op[bi] : 2'd0;
      if (found) taken[bi] = 1'b1;
    end

    busy = e_v & ~taken;
    for (int k = 0; k < N; k++) begin
      put[k]     = 1'b0;
      put_idx[k] = '0;
      if (disp_valid[k])
        for (int i = 0; i < S; i++)
          if (!busy[i] && !put[k]) begin
            put[k]     = 1'b1;
            put_idx[k] = IW'(i);
          end
      if (put[k]) busy[put_idx[k]] = 1'b1;
      d1r[k] = !disp_s1_use[k] | disp_s1_rdy[k] | hit(disp_s1_tag[k], cmp_valid, cmp_tag);
      d2r[k] = !disp_s2_use[k] | disp_s2_rdy[k] | hit(disp_s2_tag[k], cmp_valid, cmp_tag);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_v <= '0;
    end else begin
      e_r1 <= w1;
      e_r2 <= w2;
      e_v  <= e_v & ~taken;
      for (int k = 0; k < N; k++)
        if (put[k]) begin
          e_v[put_idx[k]]   <= 1'b1;
          e_tag[put_idx[k]] <= disp_tag[k];
          e_op[put_idx[k]]  <= disp_op[k];
          e_t1[put_idx[k]]  <= disp_s1_tag[k];
          e_t2[put_idx[k]]  <= disp_s2_tag[k];
          e_r1[put_idx[k]]  <= d1r[k];
          e_r2[put_idx[k]]  <= d2r[k];
        end
    end
  end

  assign occupancy = CW'($countones(e_v));
  assign iss_cnt   = CW'($countones(iss_valid));
  assign disp_cnt  = CW'($countones(disp_valid));
  assign free_cnt  = CW'(S) - occupancy + iss_cnt;

  // R4
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CW'(S));

  // R4
  occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> occupancy == $past(occupancy) - $past(iss_cnt) + $past(disp_cnt));

  // R7
  disp_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_cnt <= free_cnt);

  // R3
  grant_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand & ~taken) != '0 |-> iss_valid[N-1]);

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> occupancy == '0);

  generate
    for (genvar k = 1; k < N; k++) begin : g_order
      // R3
      age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[k] |-> iss_valid[k-1] && iss_tag[k-1] < iss_tag[k]);
    end
  endgenerate
endmodule

// File: tb/wakeup_select_sched_tb.sv
module wakeup_select_sched_tb_top;
  localparam int S = 4, N = 2, C = 4, TW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] disp_valid, disp_s1_use, disp_s1_rdy, disp_s2_use, disp_s2_rdy;
  logic [N-1:0][TW-1:0] disp_tag, disp_s1_tag, disp_s2_tag;
  logic [N-1:0][1:0] disp_op;
  logic [C-1:0] cmp_valid;
  logic [C-1:0][TW-1:0] cmp_tag;
  logic [N-1:0] iss_valid;
  logic [N-1:0][TW-1:0] iss_tag;
  logic [N-1:0][1:0] iss_op;
  logic [2:0] occupancy;

  int tests = 0, fails = 0;
  bit done = 0;
  int tg [4] = '{5, 2, 7, 3};

  always #4 clk = ~clk;

  wakeup_select_sched #(.S(S), .N(N), .C(C), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_tag(disp_tag),
    .disp_op(disp_op), .disp_s1_use(disp_s1_use), .disp_s1_rdy(disp_s1_rdy),
    .disp_s1_tag(disp_s1_tag), .disp_s2_use(disp_s2_use), .disp_s2_rdy(disp_s2_rdy),
    .disp_s2_tag(disp_s2_tag), .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_op(iss_op), .occupancy(occupancy));

  task automatic clear_in();
    disp_valid = '0; disp_tag = '0; disp_op = '0;
    disp_s1_use = '0; disp_s1_rdy = '0; disp_s1_tag = '0;
    disp_s2_use = '0; disp_s2_rdy = '0; disp_s2_tag = '0;
    cmp_valid = '0; cmp_tag = '0;
  endtask

  task automatic put(input int k, input int tag, input int op, input bit use1, input int t1);
    disp_valid[k] = 1'b1; disp_tag[k] = TW'(tag); disp_op[k] = 2'(op);
    disp_s1_use[k] = use1; disp_s1_rdy[k] = 1'b0; disp_s1_tag[k] = TW'(t1);
  endtask

  task automatic next();
    @(negedge clk); clear_in(); #1;
  endtask

  task automatic chk_occ(input int exp, input string req);
    tests++;
    if (occupancy !== 3'(exp)) begin
      fails++;
      $display("FAIL %s occupancy got %0d expected %0d", req, occupancy, exp);
    end
  endtask

  task automatic chk_slot(input int k, input bit v, input int tag, input int op, input string req);
    tests++;
    if (iss_valid[k] !== v || (v && (iss_tag[k] !== TW'(tag) || iss_op[k] !== 2'(op)))) begin
      fails++;
      $display("FAIL %s slot%0d got v=%0b tag=%0d op=%0d expected v=%0b tag=%0d op=%0d",
               req, k, iss_valid[k], iss_tag[k], iss_op[k], v, tag, op);
    end
  endtask

  // expected grants: two lowest tags among avail entries (R3, R10)
  task automatic expect_grants(input logic [3:0] avail, input string req, output logic [3:0] took);
    int e0 = -1, e1 = -1;
    for (int j = 0; j < 4; j++) if (avail[j] && (e0 < 0 || tg[j] < tg[e0])) e0 = j;
    for (int j = 0; j < 4; j++) if (avail[j] && j != e0 && (e1 < 0 || tg[j] < tg[e1])) e1 = j;
    chk_slot(0, e0 >= 0, e0 >= 0 ? tg[e0] : 0, e0 >= 0 ? e0 : 0, req);
    chk_slot(1, e1 >= 0, e1 >= 0 ? tg[e1] : 0, e1 >= 0 ? e1 : 0, req);
    took = '0;
    if (e0 >= 0) took[e0] = 1'b1;
    if (e1 >= 0) took[e1] = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; clear_in();
    @(negedge clk); @(negedge clk); rst_n = 1'b1; #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] rem, rdy, took;
    clear_in();
    do_reset();
    // R1 reset state
    chk_occ(0, "R1");
    tests++;
    if (iss_valid !== '0) begin fails++; $display("FAIL R1 iss_valid got %b expected 00", iss_valid); end

    // Sweep: entry j waits on tag 8+j unless p[j] is set (R2, R3, R5, R6, R8, R10)
    for (int p = 0; p < 16; p++) begin
      do_reset();
      @(negedge clk); clear_in();
      for (int j = 0; j < 2; j++) put(j, tg[j], j, !p[j], 8 + j);
      #1; chk_occ(0, "R8");
      @(negedge clk); clear_in();
      for (int j = 2; j < 4; j++) put(j - 2, tg[j], j, !p[j], 8 + j);
      #1;
      rem = 4'b0011; rdy = 4'(p);
      expect_grants(rem & rdy, "R8", took);
      rem = (rem & ~took) | 4'b1100;
      next();
      chk_occ($countones(rem), "R4");
      expect_grants(rem & rdy, "R2", took);
      rem &= ~took;
      @(negedge clk); clear_in();
      for (int c = 0; c < 4; c++) begin cmp_valid[c] = 1'b1; cmp_tag[c] = TW'(8 + c); end
      #1;
      chk_occ($countones(rem), "R4");
      rdy = 4'b1111;
      expect_grants(rem & rdy, "R5", took);
      rem &= ~took;
      for (int s = 0; s < 2; s++) begin
        next();
        chk_occ($countones(rem), "R4");
        expect_grants(rem & rdy, "R6", took);
        rem &= ~took;
      end
      chk_occ(0, "R4");
    end

    // Refill while full, with same-cycle wakeup and dispatch capture (R5, R7, R9, R6)
    do_reset();
    @(negedge clk); clear_in();
    put(0, 0, 0, 1, 12); put(1, 1, 1, 1, 12);
    @(negedge clk); clear_in();
    put(0, 2, 2, 1, 12); put(1, 3, 3, 1, 12);
    #1; chk_slot(0, 0, 0, 0, "R2");
    next();
    chk_occ(4, "R7");
    chk_slot(0, 0, 0, 0, "R2");
    @(negedge clk); clear_in();
    cmp_valid[0] = 1'b1; cmp_tag[0] = 4'd12;
    cmp_valid[2] = 1'b1; cmp_tag[2] = 4'd9;
    put(0, 4, 1, 0, 0); put(1, 5, 2, 1, 9);
    #1;
    chk_slot(0, 1, 0, 0, "R5");
    chk_slot(1, 1, 1, 1, "R5");
    next();
    chk_occ(4, "R7");
    chk_slot(0, 1, 2, 2, "R6");
    chk_slot(1, 1, 3, 3, "R6");
    next();
    chk_occ(2, "R4");
    chk_slot(0, 1, 4, 1, "R9");
    chk_slot(1, 1, 5, 2, "R9");
    next();
    chk_occ(0, "R4");

    // Full-width unsigned ordering, older entry in a higher slot (R3)
    do_reset();
    @(negedge clk); clear_in();
    put(0, 14, 3, 0, 0); put(1, 9, 1, 0, 0);
    #1; chk_slot(0, 0, 0, 0, "R8");
    next();
    chk_slot(0, 1, 9, 1, "R3");
    chk_slot(1, 1, 14, 3, "R3");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule